// File: doc/BRIEF.md
# Floating-Point Operand Unpack Classifier

This block turns one 64-bit operand word into the unpacked form that a floating-point datapath works on internally. A 2-bit type code says how the word is to be read. It can be a 32-bit signed integer, a 64-bit signed integer, a single-precision float or a double-precision float.

The result has five parts: a sign, a signed unbiased exponent, a 64-bit mantissa and a class code, plus a sticky bit that is always cleared. A nonzero number has its leading one at mantissa bit 63. The value is then mant / 2^63 * 2^exp. Integers and denormal floats share one leading-zero count and left-shift path with normal floats. Signalling NaNs are made quiet on entry, get their own class, and raise an invalid-operand flag.

Inputs are taken with a valid/ready handshake. The result is registered and appears one cycle after the input is accepted, marked by a valid strobe.

Top module: `opnd_unpack`

## Requirements
- R1: Type code 0 means a 32-bit integer, 1 a 64-bit integer, 2 single precision and 3 double precision. `in_ready` is high. During reset `out_valid` and `out_invalid` are low. Once reset is released, an input accepted at a clock edge shows its result on the outputs after that edge, with `out_valid` high.
- R2: A zero integer, or a float with zero exponent and zero fraction, gives class 0 (zero), with exponent 0, mantissa 0 and the input's sign kept.
- R3: A normal float gives class 1 (number) with exponent = biased exponent - bias (127 for single, 1023 for double). Its mantissa is a one at bit 63 followed by the fraction bits, most significant first.
- R4: A denormal float (zero exponent, nonzero fraction) gives class 1. Its exponent is 1 - bias minus the left shift that puts its leading fraction one at bit 63, and no hidden one is added.
- R5: A nonzero integer is turned into sign and magnitude and gives class 1. Its exponent is the bit position of the magnitude's leading one, and that one lands at bit 63. The most negative value of either width converts exactly.
- R6: The sign is bit 63 of the word, except for a 32-bit integer, where it is bit 31. A single float uses only bits 63:32 of the word and a 32-bit integer only bits 31:0. The other bits have no effect.
- R7: A float with an all-ones exponent gives class 2 (infinity) when its fraction is zero. Otherwise it is a NaN. In both cases the exponent is 0, mantissa bit 63 is 0 and the fraction sits from bit 62 down.
- R8: A NaN whose top fraction bit (mantissa bit 62) is set gives class 3 (quiet NaN). When that bit is clear, it is forced to one, the class is 4 (signalling NaN) and `out_invalid` goes high.
- R9: `out_invalid` is low for every class other than 4, and `out_sticky` is always low.
- R10: While no input is accepted, every output keeps its value, even when `in_type` and `in_word` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_type | input | 2 | Format code of the operand |
| in_word | input | 64 | Operand word |
| out_valid | output | 1 | Result valid, held |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Signed unbiased exponent |
| out_mant | output | MANT_W | Mantissa, leading one at the top bit |
| out_sticky | output | 1 | Sticky bit, always cleared |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Invalid-operand flag |

## Verification
The hardest cases are the extremes of the shared normalizer: the smallest denormals, which need shifts of 23 and 52, and the most negative integers, whose negated magnitude has only the top bit set. These are reached with hand-chosen operand words whose expected exponent and mantissa are worked out by hand.

The invalid flag's hold behaviour is another hard case. A signalling NaN is followed by idle cycles in which the word and type inputs change, and then by a quiet NaN. This shows that the flag holds through the idle cycles and falls on the next accepted input.

// File: rtl/opnd_unpack_pkg.sv
package opnd_unpack_pkg;

    localparam int WORD_W   = 64;
    localparam int SGL_EB   = 8;
    localparam int SGL_FB   = 23;
    localparam int DBL_EB   = 11;
    localparam int DBL_FB   = 52;

    typedef enum logic [1:0] {
        TYP_I32 = 2'd0,
        TYP_I64 = 2'd1,
        TYP_SGL = 2'd2,
        TYP_DBL = 2'd3
    } typ_e;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } cls_e;

endpackage

// File: rtl/opnd_unpack_lzc.sv
module opnd_unpack_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  d,
    output logic [CW-1:0] cnt
);
    // Scans upward so the highest set bit decides; zero input yields W.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (d[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/opnd_unpack_ieee.sv
module opnd_unpack_ieee
    import opnd_unpack_pkg::*;
#(
    parameter int EB     = 8,
    parameter int FB     = 23,
    parameter int MANT_W = 64,
    parameter int EXP_W  = 13
) (
    input  logic [EB-1:0]            e_bits,
    input  logic [FB-1:0]            f_bits,
    output cls_e                     cls,
    output logic signed [EXP_W-1:0]  exp_raw,
    output logic [MANT_W-1:0]        mant_raw
);
    localparam int BIAS = (1 << (EB - 1)) - 1;
    localparam logic signed [EXP_W-1:0] BIAS_S = EXP_W'(BIAS);
    localparam logic signed [EXP_W-1:0] DEN_S  = EXP_W'(1 - BIAS);
    localparam logic [EB-1:0]           EMAX   = '1;

    logic [MANT_W-1:0] frac_al;
    logic              frac_nz;

    assign frac_al = {1'b0, f_bits, {(MANT_W - 1 - FB){1'b0}}};
    assign frac_nz = |f_bits;

    always_comb begin
        cls      = CLS_NUM;
        exp_raw  = '0;
        mant_raw = frac_al;
        if (e_bits == '0) begin
            if (!frac_nz) begin
                cls      = CLS_ZERO;
                mant_raw = '0;
            end else begin
                exp_raw  = DEN_S;
            end
        end else if (e_bits == EMAX) begin
            cls = frac_nz ? CLS_QNAN : CLS_INF;
        end else begin
            exp_raw              = $signed(EXP_W'(e_bits)) - BIAS_S;
            mant_raw[MANT_W-1]   = 1'b1;
        end
    end
endmodule

// File: rtl/opnd_unpack_decode.sv
module opnd_unpack_decode
    import opnd_unpack_pkg::*;
#(
    parameter int MANT_W = 64,
    parameter int EXP_W  = 13
) (
    input  logic [1:0]               typ,
    input  logic [WORD_W-1:0]        word,
    output logic                     sign,
    output cls_e                     cls,
    output logic signed [EXP_W-1:0]  exp_raw,
    output logic [MANT_W-1:0]        mant_raw
);
    localparam logic signed [EXP_W-1:0] INT_TOP = EXP_W'(MANT_W - 1);

    cls_e                    s_cls, d_cls;
    logic signed [EXP_W-1:0] s_exp, d_exp;
    logic [MANT_W-1:0]       s_mant, d_mant;
    logic [31:0]             lo_mag;
    logic [63:0]             wd_mag;

    opnd_unpack_ieee #(.EB(SGL_EB), .FB(SGL_FB), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_sgl (
        .e_bits   (word[62 -: SGL_EB]),
        .f_bits   (word[32 +: SGL_FB]),
        .cls      (s_cls),
        .exp_raw  (s_exp),
        .mant_raw (s_mant)
    );

    opnd_unpack_ieee #(.EB(DBL_EB), .FB(DBL_FB), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_dbl (
        .e_bits   (word[62 -: DBL_EB]),
        .f_bits   (word[0 +: DBL_FB]),
        .cls      (d_cls),
        .exp_raw  (d_exp),
        .mant_raw (d_mant)
    );

    // Two's complement to magnitude; the most negative value maps to 2^(N-1).
    assign lo_mag = word[31] ? (~word[31:0] + 32'd1) : word[31:0];
    assign wd_mag = word[63] ? (~word + 64'd1) : word;

    always_comb begin
        sign     = word[63];
        cls      = CLS_NUM;
        exp_raw  = INT_TOP;
        mant_raw = '0;
        unique case (typ)
            TYP_I32: begin
                sign     = word[31];
                mant_raw = MANT_W'(lo_mag);
                cls      = (lo_mag == '0) ? CLS_ZERO : CLS_NUM;
            end
            TYP_I64: begin
                mant_raw = MANT_W'(wd_mag);
                cls      = (wd_mag == '0) ? CLS_ZERO : CLS_NUM;
            end
            TYP_SGL: begin
                cls      = s_cls;
                exp_raw  = s_exp;
                mant_raw = s_mant;
            end
            default: begin
                cls      = d_cls;
                exp_raw  = d_exp;
                mant_raw = d_mant;
            end
        endcase
        if (cls == CLS_ZERO) exp_raw = '0;
    end
endmodule

// File: rtl/opnd_unpack.sv
module opnd_unpack
    import opnd_unpack_pkg::*;
#(
    parameter int MANT_W = 64,
    parameter int EXP_W  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_type,
    input  logic [WORD_W-1:0]        in_word,
    output logic                     out_valid,
    output logic                     out_sign,
    output logic signed [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0]        out_mant,
    output logic                     out_sticky,
    output logic [2:0]               out_class,
    output logic                     out_invalid
);
    localparam int CW = $clog2(MANT_W + 1);
    localparam int QB = MANT_W - 2;

    typedef struct packed {
        logic                    vld;
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
        cls_e                    cls;
        logic                    inv;
    } res_t;

    res_t                    res_d, res_q;
    logic                    dec_sign;
    cls_e                    dec_cls;
    logic signed [EXP_W-1:0] dec_exp;
    logic [MANT_W-1:0]       dec_mant;
    logic [CW-1:0]           lz_cnt;
    logic                    take;

    assign in_ready = 1'b1;
    assign take     = in_valid && in_ready;

    opnd_unpack_decode #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dec (
        .typ      (in_type),
        .word     (in_word),
        .sign     (dec_sign),
        .cls      (dec_cls),
        .exp_raw  (dec_exp),
        .mant_raw (dec_mant)
    );

    opnd_unpack_lzc #(.W(MANT_W), .CW(CW)) u_lzc (
        .d   (dec_mant),
        .cnt (lz_cnt)
    );

    always_comb begin
        res_d = res_q;
        if (take) begin
            res_d.vld  = 1'b1;
            res_d.sign = dec_sign;
            res_d.cls  = dec_cls;
            res_d.exp  = dec_exp;
            res_d.mant = dec_mant;
            res_d.inv  = 1'b0;
            if (dec_cls == CLS_NUM) begin
                res_d.mant = dec_mant << lz_cnt;
                res_d.exp  = dec_exp - $signed(EXP_W'(lz_cnt));
            end
            if (dec_cls == CLS_QNAN && !dec_mant[QB]) begin
                res_d.mant[QB] = 1'b1;
                res_d.cls      = CLS_SNAN;
                res_d.inv      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.vld;
    assign out_sign    = res_q.sign;
    assign out_exp     = res_q.exp;
    assign out_mant    = res_q.mant;
    assign out_sticky  = 1'b0;
    assign out_class   = res_q.cls;
    assign out_invalid = res_q.inv;
endmodule

// File: rtl/opnd_unpack_chk.sv
module opnd_unpack_chk
    import opnd_unpack_pkg::*;
#(
    parameter int MANT_W = 64,
    parameter int EXP_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant,
    input logic [2:0]        out_class,
    input logic              out_invalid
);
    AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R1
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'(CLS_ZERO)) |-> (out_mant == '0 && out_exp == '0)); // R2
    AST_NUM_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'(CLS_NUM)) |-> out_mant[MANT_W-1]); // R5
    AST_SPECIAL_NO_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class == 3'(CLS_INF) || out_class == 3'(CLS_QNAN) || out_class == 3'(CLS_SNAN)))
        |-> !out_mant[MANT_W-1]); // R7
    AST_SNAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'(CLS_SNAN)) |-> (out_mant[MANT_W-2] && out_invalid)); // R8
    AST_INVALID_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_class == 3'(CLS_SNAN))); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(out_mant) && $stable(out_exp) && $stable(out_class)
                                     && $stable(out_sign) && $stable(out_invalid) && $stable(out_valid))); // R10
endmodule

bind opnd_unpack opnd_unpack_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_sign    (out_sign),
    .out_exp     (out_exp),
    .out_mant    (out_mant),
    .out_class   (out_class),
    .out_invalid (out_invalid)
);

// File: tb/opnd_unpack_bench.sv
module opnd_unpack_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_type = 2'd0;
    logic [63:0] in_word = 64'd0;
    logic        out_valid, out_sign, out_sticky, out_invalid;
    logic [12:0] out_exp;
    logic [63:0] out_mant;
    logic [2:0]  out_class;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]  cls;
        logic        sgn;
        int          ex;
        logic [63:0] mt;
        logic        inv;
        string       req;
    } exp_t;

    exp_t q[$];
    logic acc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_unpack u_opnd_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_word(in_word), .out_valid(out_valid),
        .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
        .out_sticky(out_sticky), .out_class(out_class), .out_invalid(out_invalid)
    );

    task automatic drive(input logic [1:0] t, input logic [63:0] w, input logic [2:0] c,
                         input logic s, input int e, input logic [63:0] m,
                         input logic iv, input string r);
        exp_t it;
        it.cls = c; it.sgn = s; it.ex = e; it.mt = m; it.inv = iv; it.req = r;
        q.push_back(it);
        in_type  = t;
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: one accepted input at a posedge is compared at the next negedge.
    always @(posedge clk) acc <= in_valid && in_ready && rst_n;

    always @(negedge clk) begin
        if (acc) begin
            exp_t e;
            n_run++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected result, actual class=%0d expected none", out_class);
            end else begin
                e = q.pop_front();
                if (!out_valid || out_class !== e.cls || out_sign !== e.sgn ||
                    $signed(out_exp) != e.ex || out_mant !== e.mt ||
                    out_invalid !== e.inv || out_sticky !== 1'b0) begin
                    n_fail++;
                    $display("FAIL %s: actual v=%0b cls=%0d s=%0b exp=%0d mant=%h inv=%0b stk=%0b expected cls=%0d s=%0b exp=%0d mant=%h inv=%0b stk=0",
                             e.req, out_valid, out_class, out_sign, $signed(out_exp), out_mant,
                             out_invalid, out_sticky, e.cls, e.sgn, e.ex, e.mt, e.inv);
                end
            end
        end
    end

    // Idle cycles with changing inputs: every output must hold (R10).
    task automatic idle_hold(input int n);
        logic [2:0]  c0; logic s0, i0, v0; logic [12:0] e0; logic [63:0] m0;
        c0 = out_class; s0 = out_sign; i0 = out_invalid; v0 = out_valid; e0 = out_exp; m0 = out_mant;
        for (int k = 0; k < n; k++) begin
            in_type = 2'(k);
            in_word = 64'h0123_4567_89AB_CDEF ^ 64'(k * 977);
            @(negedge clk);
            n_run++;
            if (out_class !== c0 || out_sign !== s0 || out_invalid !== i0 ||
                out_valid !== v0 || out_exp !== e0 || out_mant !== m0) begin
                n_fail++;
                $display("FAIL R10: actual cls=%0d inv=%0b mant=%h expected cls=%0d inv=%0b mant=%h",
                         out_class, out_invalid, out_mant, c0, i0, m0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_invalid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: reset actual v=%0b inv=%0b rdy=%0b expected v=0 inv=0 rdy=1",
                     out_valid, out_invalid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5 / R6: integers
        drive(2'd0, 64'h0,                     3'd0, 1'b0, 0,  64'h0, 1'b0, "R2");
        drive(2'd0, 64'h0000_0000_0000_0001,   3'd1, 1'b0, 0,  64'h8000_0000_0000_0000, 1'b0, "R5");
        drive(2'd0, 64'h0000_0000_FFFF_FFFF,   3'd1, 1'b1, 0,  64'h8000_0000_0000_0000, 1'b0, "R5");
        drive(2'd0, 64'hDEAD_BEEF_8000_0000,   3'd1, 1'b1, 31, 64'h8000_0000_0000_0000, 1'b0, "R6");
        drive(2'd0, 64'hFFFF_FFFF_0000_0005,   3'd1, 1'b0, 2,  64'hA000_0000_0000_0000, 1'b0, "R6");
        drive(2'd1, 64'h8000_0000_0000_0000,   3'd1, 1'b1, 63, 64'h8000_0000_0000_0000, 1'b0, "R5");
        drive(2'd1, 64'hFFFF_FFFF_FFFF_FFFA,   3'd1, 1'b1, 2,  64'hC000_0000_0000_0000, 1'b0, "R5");
        drive(2'd1, 64'h0,                     3'd0, 1'b0, 0,  64'h0, 1'b0, "R2");
        // singles
        drive(2'd2, 64'h3F80_0000_1234_5678,   3'd1, 1'b0, 0,  64'h8000_0000_0000_0000, 1'b0, "R3");
        drive(2'd2, 64'h8000_0000_0000_0000,   3'd0, 1'b1, 0,  64'h0, 1'b0, "R2");
        drive(2'd2, 64'h0000_0001_0000_0000,   3'd1, 1'b0, -149, 64'h8000_0000_0000_0000, 1'b0, "R4");
        drive(2'd2, 64'h007F_FFFF_FFFF_FFFF,   3'd1, 1'b0, -127, 64'hFFFF_FE00_0000_0000, 1'b0, "R4");
        drive(2'd2, 64'hFF80_0000_0000_0000,   3'd2, 1'b1, 0,  64'h0, 1'b0, "R7");
        drive(2'd2, 64'h7FC0_0001_0000_0000,   3'd3, 1'b0, 0,  64'h4000_0100_0000_0000, 1'b0, "R8");
        drive(2'd2, 64'h7F80_0001_0000_0000,   3'd4, 1'b0, 0,  64'h4000_0100_0000_0000, 1'b1, "R8");
        // doubles
        drive(2'd3, 64'h3FF8_0000_0000_0000,   3'd1, 1'b0, 0,  64'hC000_0000_0000_0000, 1'b0, "R3");
        drive(2'd3, 64'h0000_0000_0000_0001,   3'd1, 1'b0, -1074, 64'h8000_0000_0000_0000, 1'b0, "R4");
        drive(2'd3, 64'h7FEF_FFFF_FFFF_FFFF,   3'd1, 1'b0, 1023, 64'hFFFF_FFFF_FFFF_F800, 1'b0, "R3");
        drive(2'd3, 64'hFFF0_0000_0000_0001,   3'd4, 1'b1, 0,  64'h4000_0000_0000_0800, 1'b1, "R8");
        @(negedge clk);
        idle_hold(4);
        drive(2'd3, 64'h7FF8_0000_0000_0000,   3'd3, 1'b0, 0,  64'h4000_0000_0000_0000, 1'b0, "R9");
        drive(2'd3, 64'h7FF0_0000_0000_0000,   3'd2, 1'b0, 0,  64'h0, 1'b0, "R7");
        @(negedge clk);
        idle_hold(3);
        @(negedge clk);

        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: actual %0d results missing expected 0", q.size());
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule